// File: doc/BRIEF.md
# OTP memory command sequencer

This block is the byte-level transaction engine of a single-wire identification memory. A bit-level engine in front of it turns bus time slots into bytes. Every byte the host writes reaches the sequencer on a valid/ready receive channel. Every byte the host reads is requested with a one-cycle pulse and answered one cycle later. All bytes are LSB first on the wire, so the sequencer sees plain bytes and shifts them into its CRC bit 0 first.

The sequencer holds a 64-bit identity image (family code, 48-bit serial number, check byte), a 1024-bit one-time-programmable data array of four 32-byte pages, an 8-byte one-time-programmable status field, and an 8-byte staging buffer. It decodes identity and select commands, then the memory and status commands. It produces every CRC the host uses to confirm what was sent or received. It programs the arrays, which can only clear bits, when the host sends the program code while the programming-voltage input is high.

Receive back-pressure: a byte transfers only in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low for as long as the sequencer is waiting to send data, and the bit engine must hold its byte until ready returns. A read request never stalls. Each `tx_req` pulse is answered by `tx_valid` on the next cycle. When no data is pending the answer is FFh.

Top module: `otp_seq`

## Requirements
- R1: After `rst_n`, every data-array bit and status bytes 0 to 6 read as 1 and status byte 7 reads 00h. Programming ANDs new data into stored bytes, so a stored bit can never return from 0 to 1.
- R2: After a bus reset, code 33h makes the next eight reads return the family code, then the six serial-number bytes with the least significant first, then the CRC of those seven bytes. Any read after that returns FFh.
- R3: Memory, status and profile codes are taken only as the byte that follows CCh. If one arrives as the first byte after a bus reset, every later read returns FFh until the next bus reset.
- R4: For F0h, C3h, 0Fh and AAh, the sequencer takes the address low byte and then the high byte, and the next read returns the CRC of the code byte and both address bytes. The CRC is x^8+x^5+x^4+1 with a zero seed, and the data is fed bit 0 first.
- R5: F0h streams data bytes from the start address to byte 127. It then returns one CRC of all the streamed bytes, and reads FFh from then on.
- R6: C3h streams data bytes. After each byte at a 32-byte page end it returns the CRC of the bytes sent since the start or since the previous page CRC. It continues with the next page and stops after the CRC of page 3, with FFh from then on.
- R7: AAh streams the status bytes from the start address to byte 7. It then returns their CRC, and reads FFh from then on.
- R8: 0Fh ignores the low three address bits. After the address CRC it clears the CRC, takes eight data bytes into the staging buffer and returns their CRC. On 5Ah it programs them into the addressed 8-byte segment, returns the eight stored bytes, and reads FFh from then on.
- R9: 55h takes the address and one data byte and returns the CRC of those four bytes. On 5Ah it programs that status byte and returns its stored value. It then increments the address and loads the new address low byte into the CRC register as its value. The next data byte is shifted in and that CRC is returned, and this repeats up to status byte 7.
- R10: A status byte 0 bit n at 0 write-protects data page n (n = 0 to 3). A data program aimed at a protected page leaves the page unchanged.
- R11: A 5Ah received while `vpp_ok` is low changes nothing, and the sequencer keeps waiting for the program code.
- R12: A `bus_rst` pulse in any state returns the sequencer to wait for an identity or select code.
- R13: `tx_req` is answered on the next cycle by `tx_valid`, with FFh when no data is pending. `rx_ready` is high in every receive or idle state and low while the sequencer is waiting to send data.
- R14: The byte after CCh, 99h, makes the next read return 55h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, erases the arrays to their blank state |
| bus_rst | input | 1 | Bus reset seen by the bit engine, one-cycle pulse |
| vpp_ok | input | 1 | Programming voltage present |
| rx_valid | input | 1 | Host-written byte offered |
| rx_ready | output | 1 | Sequencer accepts a host-written byte |
| rx_byte | input | 8 | Host-written byte |
| tx_req | input | 1 | Host read slot group needs a byte, one-cycle pulse |
| tx_valid | output | 1 | Answer to the previous cycle's request |
| tx_byte | output | 8 | Byte returned to the host |

## Verification
A read answer is due one cycle after the edge that samples `tx_req`, because it passes through a single output register. A received byte takes effect at the edge where `rx_valid` and `rx_ready` are both high. A program write lands on that same edge, so the first read request after it already sees the new array contents. The bench drives every input on a falling edge and samples `tx_byte` on the next falling edge, half a cycle after the answering edge. It keeps its own model of the arrays and of the CRC and compares every byte of each stream against that model.

// File: rtl/otp_seq_pkg.sv
`timescale 1ns/1ps
package otp_seq_pkg;

  typedef enum logic [4:0] {
    S_ROM, S_ID, S_FCMD, S_PROF, S_ALO, S_AHI, S_ACRC, S_RD, S_RDCRC,
    S_WMDAT, S_WMCRC, S_WMPGM, S_WMVFY, S_WSDAT, S_WSCRC, S_WSPGM, S_WSVFY, S_IDLE
  } seq_state_e;

  localparam logic [7:0] OP_ID_READ  = 8'h33;
  localparam logic [7:0] OP_SELECT   = 8'hCC;
  localparam logic [7:0] OP_RD_FIELD = 8'hF0;
  localparam logic [7:0] OP_RD_PAGE  = 8'hC3;
  localparam logic [7:0] OP_WR_MEM   = 8'h0F;
  localparam logic [7:0] OP_RD_STAT  = 8'hAA;
  localparam logic [7:0] OP_WR_STAT  = 8'h55;
  localparam logic [7:0] OP_PROFILE  = 8'h99;
  localparam logic [7:0] OP_PROGRAM  = 8'h5A;
  localparam logic [7:0] PROFILE_ANS = 8'h55;

  // reflected form of x^8+x^5+x^4+1, data bit 0 first
  function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic       fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  function automatic logic [7:0] id_crc(input logic [7:0] fam, input logic [47:0] ser);
    logic [7:0] c;
    c = crc8_byte(8'h00, fam);
    for (int i = 0; i < 6; i++) c = crc8_byte(c, ser[8*i +: 8]);
    return c;
  endfunction

endpackage

// File: rtl/otp_crc8.sv
`timescale 1ns/1ps
module otp_crc8
  import otp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       sh,
  input  logic [7:0] sh_byte,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= 8'h00;
    else if (clr) crc <= 8'h00;
    else if (ld)  crc <= ld_val;
    else if (sh)  crc <= crc8_byte(crc, sh_byte);
  end
endmodule

// File: rtl/otp_arrays.sv
`timescale 1ns/1ps
module otp_arrays #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 32,
  parameter int SEG_BYTES  = 8,
  parameter int STAT_BYTES = 8,
  localparam int DATA_BYTES = PAGES * PAGE_BYTES,
  localparam int SEGS       = DATA_BYTES / SEG_BYTES,
  localparam int SGW        = $clog2(SEGS),
  localparam int SAW        = $clog2(STAT_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      seg_we,
  input  logic [SGW-1:0]            seg_sel,
  input  logic [SEG_BYTES*8-1:0]    seg_mask,
  input  logic                      st_we,
  input  logic [SAW-1:0]            st_sel,
  input  logic [7:0]                st_mask,
  output logic [DATA_BYTES*8-1:0]   data_flat,
  output logic [STAT_BYTES*8-1:0]   stat_flat
);
  // data array: one register per byte, write gated by the page protect bit
  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_data
    localparam int PG = b / PAGE_BYTES;
    localparam int SG = b / SEG_BYTES;
    localparam int OF = b % SEG_BYTES;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'hFF;
      else if (seg_we && seg_sel == SGW'(SG) && stat_flat[PG])
        q <= q & seg_mask[8*OF +: 8];
    end
    assign data_flat[8*b +: 8] = q;
  end

  // status field: last byte fixed at zero
  for (genvar s = 0; s < STAT_BYTES; s++) begin : g_stat
    logic [7:0] q;
    if (s == STAT_BYTES - 1) begin : g_fixed
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 8'h00;
        else        q <= 8'h00;
      end
    end else begin : g_prog
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 8'hFF;
        else if (st_we && st_sel == SAW'(s)) q <= q & st_mask;
      end
    end
    assign stat_flat[8*s +: 8] = q;
  end
endmodule

// File: rtl/otp_seq.sv
`timescale 1ns/1ps
module otp_seq
  import otp_seq_pkg::*;
#(
  parameter logic [7:0]  ID_FAMILY  = 8'h09,
  parameter logic [47:0] ID_SERIAL  = 48'h7E61_0F12_A5C3,
  parameter int          PAGES      = 4,
  parameter int          PAGE_BYTES = 32,
  parameter int          SEG_BYTES  = 8,
  parameter int          STAT_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       vpp_ok,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  localparam int DATA_BYTES = PAGES * PAGE_BYTES;
  localparam int DAW        = $clog2(DATA_BYTES);
  localparam int PBW        = $clog2(PAGE_BYTES);
  localparam int SAW        = $clog2(STAT_BYTES);
  localparam int CW         = $clog2(SEG_BYTES);
  localparam int SGW        = DAW - CW;
  localparam int CNTW       = (CW > 3) ? CW : 3;
  localparam logic [63:0] ROM_IMAGE = {id_crc(ID_FAMILY, ID_SERIAL), ID_SERIAL, ID_FAMILY};

  seq_state_e st, st_n;
  logic [15:0] addr, addr_n, addr_inc;
  logic [7:0]  mode, mode_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic [SEG_BYTES*8-1:0] stage_q, stage_n;
  logic [7:0]  tx_d;
  logic        rx_take;

  logic        crc_clr, crc_ld, crc_sh;
  logic [7:0]  crc_ldv, crc_in, crc;
  logic        seg_we, st_we;

  logic [DATA_BYTES*8-1:0] data_flat;
  logic [STAT_BYTES*8-1:0] stat_flat;

  logic        mem_ok, stat_ok, in_range, last_byte;
  logic [7:0]  data_byte, stat_byte, vfy_byte, rd_byte;

  otp_crc8 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .ld(crc_ld), .ld_val(crc_ldv),
    .sh(crc_sh), .sh_byte(crc_in), .crc(crc)
  );

  otp_arrays #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .SEG_BYTES(SEG_BYTES), .STAT_BYTES(STAT_BYTES)
  ) u_arr (
    .clk(clk), .rst_n(rst_n),
    .seg_we(seg_we), .seg_sel(addr[DAW-1:CW]), .seg_mask(stage_q),
    .st_we(st_we), .st_sel(addr[SAW-1:0]), .st_mask(stage_q[7:0]),
    .data_flat(data_flat), .stat_flat(stat_flat)
  );

  // read-side decode
  assign mem_ok    = addr < 16'(DATA_BYTES);
  assign stat_ok   = addr < 16'(STAT_BYTES);
  assign addr_inc  = addr + 16'd1;
  assign data_byte = data_flat[{addr[DAW-1:0], 3'b000} +: 8];
  assign stat_byte = stat_flat[{addr[SAW-1:0], 3'b000} +: 8];
  assign vfy_byte  = data_flat[{addr[DAW-1:CW], cnt[CW-1:0], 3'b000} +: 8];
  assign in_range  = (mode == OP_RD_STAT) ? stat_ok : mem_ok;
  assign rd_byte   = (mode == OP_RD_STAT) ? stat_byte : data_byte;

  always_comb begin
    if (mode == OP_RD_STAT)      last_byte = addr == 16'(STAT_BYTES - 1);
    else if (mode == OP_RD_PAGE) last_byte = &addr[PBW-1:0];
    else                         last_byte = addr == 16'(DATA_BYTES - 1);
  end

  always_comb begin
    case (st)
      S_ROM, S_FCMD, S_ALO, S_AHI, S_WMDAT, S_WMPGM,
      S_WSDAT, S_WSPGM, S_IDLE: rx_ready = 1'b1;
      default:                  rx_ready = 1'b0;
    endcase
  end
  assign rx_take = rx_valid && rx_ready;

  always_comb begin
    st_n    = st;
    addr_n  = addr;
    mode_n  = mode;
    cnt_n   = cnt;
    stage_n = stage_q;
    crc_clr = 1'b0;
    crc_ld  = 1'b0;
    crc_ldv = addr_inc[7:0];
    crc_sh  = 1'b0;
    crc_in  = rx_byte;
    seg_we  = 1'b0;
    st_we   = 1'b0;
    tx_d    = 8'hFF;
    unique case (st)
      S_ROM: if (rx_take) begin
        cnt_n = '0;
        if (rx_byte == OP_ID_READ) st_n = S_ID;
        else if (rx_byte == OP_SELECT) begin
          st_n    = S_FCMD;
          crc_clr = 1'b1;
        end else st_n = S_IDLE;
      end
      S_ID: if (tx_req) begin
        tx_d  = ROM_IMAGE[{cnt[2:0], 3'b000} +: 8];
        cnt_n = cnt + 1'b1;
        if (cnt[2:0] == 3'd7) st_n = S_IDLE;
      end
      S_FCMD: if (rx_take) begin
        mode_n = rx_byte;
        if (rx_byte == OP_RD_FIELD || rx_byte == OP_RD_PAGE || rx_byte == OP_WR_MEM ||
            rx_byte == OP_RD_STAT || rx_byte == OP_WR_STAT) begin
          crc_sh = 1'b1;
          st_n   = S_ALO;
        end else if (rx_byte == OP_PROFILE) st_n = S_PROF;
        else st_n = S_IDLE;
      end
      S_PROF: if (tx_req) begin
        tx_d = PROFILE_ANS;
        st_n = S_IDLE;
      end
      S_ALO: if (rx_take) begin
        addr_n[7:0] = rx_byte;
        crc_sh      = 1'b1;
        st_n        = S_AHI;
      end
      S_AHI: if (rx_take) begin
        addr_n[15:8] = rx_byte;
        if (mode == OP_WR_MEM) addr_n[CW-1:0] = '0;
        crc_sh = 1'b1;
        st_n   = (mode == OP_WR_STAT) ? S_WSDAT : S_ACRC;
      end
      S_ACRC: if (tx_req) begin
        tx_d    = crc;
        crc_clr = 1'b1;
        cnt_n   = '0;
        st_n    = (mode == OP_WR_MEM) ? S_WMDAT : S_RD;
      end
      S_RD: if (tx_req) begin
        if (!in_range) st_n = S_IDLE;
        else begin
          tx_d   = rd_byte;
          crc_sh = 1'b1;
          crc_in = rd_byte;
          addr_n = addr_inc;
          if (last_byte) st_n = S_RDCRC;
        end
      end
      S_RDCRC: if (tx_req) begin
        tx_d    = crc;
        crc_clr = 1'b1;
        st_n    = (mode == OP_RD_PAGE && mem_ok) ? S_RD : S_IDLE;
      end
      S_WMDAT: if (rx_take) begin
        stage_n[{cnt[CW-1:0], 3'b000} +: 8] = rx_byte;
        crc_sh = 1'b1;
        cnt_n  = cnt + 1'b1;
        if (cnt == CNTW'(SEG_BYTES - 1)) st_n = S_WMCRC;
      end
      S_WMCRC: if (tx_req) begin
        tx_d  = crc;
        cnt_n = '0;
        st_n  = S_WMPGM;
      end
      S_WMPGM: if (rx_take && rx_byte == OP_PROGRAM && vpp_ok) begin
        seg_we = mem_ok;
        st_n   = S_WMVFY;
      end
      S_WMVFY: if (tx_req) begin
        tx_d  = mem_ok ? vfy_byte : 8'hFF;
        cnt_n = cnt + 1'b1;
        if (cnt == CNTW'(SEG_BYTES - 1)) st_n = S_IDLE;
      end
      S_WSDAT: if (rx_take) begin
        stage_n[7:0] = rx_byte;
        crc_sh       = 1'b1;
        st_n         = S_WSCRC;
      end
      S_WSCRC: if (tx_req) begin
        tx_d = crc;
        st_n = S_WSPGM;
      end
      S_WSPGM: if (rx_take && rx_byte == OP_PROGRAM && vpp_ok) begin
        st_we = stat_ok;
        st_n  = S_WSVFY;
      end
      S_WSVFY: if (tx_req) begin
        tx_d   = stat_ok ? stat_byte : 8'hFF;
        addr_n = addr_inc;
        crc_ld = 1'b1;
        st_n   = (!stat_ok || addr == 16'(STAT_BYTES - 1)) ? S_IDLE : S_WSDAT;
      end
      S_IDLE: ;
      default: st_n = S_IDLE;
    endcase
    if (bus_rst) begin
      st_n    = S_ROM;
      crc_clr = 1'b1;
      seg_we  = 1'b0;
      st_we   = 1'b0;
      tx_d    = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_ROM;
      addr     <= '0;
      mode     <= '0;
      cnt      <= '0;
      stage_q  <= '1;
      tx_valid <= 1'b0;
      tx_byte  <= 8'hFF;
    end else begin
      st       <= st_n;
      addr     <= addr_n;
      mode     <= mode_n;
      cnt      <= cnt_n;
      stage_q  <= stage_n;
      tx_valid <= tx_req;
      tx_byte  <= tx_d;
    end
  end
endmodule

// File: rtl/otp_seq_chk.sv
`timescale 1ns/1ps
module otp_seq_chk #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_rst,
  input logic                             vpp_ok,
  input logic                             tx_req,
  input logic                             tx_valid,
  input logic                             rx_ready,
  input logic [PAGES*PAGE_BYTES*8-1:0]    data_flat,
  input logic [STAT_BYTES*8-1:0]          stat_flat
);
  AST_BITS_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_flat & ~$past(data_flat)) == '0) && ((stat_flat & ~$past(stat_flat)) == '0)); // R1

  AST_NO_VPP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> $stable(data_flat) && $stable(stat_flat)); // R11

  for (genvar p = 0; p < PAGES; p++) begin : g_wp
    AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_flat[p] |=> $stable(data_flat[p*PAGE_BYTES*8 +: PAGE_BYTES*8])); // R10
  end

  AST_BUSRST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> rx_ready); // R12

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_valid); // R13

  AST_ANSWER_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req)); // R13
endmodule

bind otp_seq otp_seq_chk #(
  .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .STAT_BYTES(STAT_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .vpp_ok(vpp_ok), .tx_req(tx_req),
  .tx_valid(tx_valid), .rx_ready(rx_ready), .data_flat(data_flat), .stat_flat(stat_flat)
);

// File: tb/sim_otp_seq.sv
`timescale 1ns/1ps
module sim_otp_seq;
  localparam logic [7:0]  FAM = 8'h09;
  localparam logic [47:0] SER = 48'h7E61_0F12_A5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, bus_rst = 1'b0, vpp_ok = 1'b0;
  logic rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic rx_ready, tx_valid;
  logic [7:0] tx_byte;
  int checks = 0, errors = 0;
  logic [7:0] mm [0:127];
  logic [7:0] sm [0:7];

  always #4 clk = ~clk;

  otp_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .vpp_ok(vpp_ok),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  function automatic logic [7:0] crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; b = tx_byte;
  endtask

  task automatic busrst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R13 ready after reset", {7'd0, rx_ready}, 8'h01);
    chk("R13 no answer after reset", {7'd0, tx_valid}, 8'h00);
    chk("R1 data blank", u0.tx_byte, 8'hFF);
    recv(r);
    chk("R13 idle answer", r, 8'hFF);
    chk("R13 answer valid", {7'd0, tx_valid}, 8'h01);
  endtask

  task automatic t_id();
    logic [7:0] r, c, e;
    busrst(); send(8'h33);
    c = 8'h00;
    for (int i = 0; i < 8; i++) begin
      e = (i == 0) ? FAM : (i == 7) ? c : SER[8*(i-1) +: 8];
      if (i < 7) c = crc(c, e);
      recv(r); chk("R2 id byte", r, e);
    end
    recv(r); chk("R2 after id", r, 8'hFF);
  endtask

  task automatic t_nosel();
    logic [7:0] r;
    busrst(); send(8'hF0); send(8'h00); send(8'h00);
    recv(r); chk("R3 no select", r, 8'hFF);
    recv(r); chk("R3 no select", r, 8'hFF);
  endtask

  task automatic t_profile();
    logic [7:0] r;
    busrst(); send(8'hCC); send(8'h99);
    recv(r); chk("R14 profile", r, 8'h55);
    recv(r); chk("R14 after profile", r, 8'hFF);
  endtask

  task automatic t_wmem(input logic [7:0] alo, input logic [63:0] d, input logic v);
    logic [7:0] r, c;
    int base, pg;
    busrst(); send(8'hCC); send(8'h0F); send(alo); send(8'h00);
    recv(r); chk("R4 write addr crc", r, crc(crc(crc(8'h00, 8'h0F), alo), 8'h00));
    c = 8'h00;
    for (int i = 0; i < 8; i++) begin
      send(d[8*i +: 8]); c = crc(c, d[8*i +: 8]);
    end
    recv(r); chk("R8 data crc", r, c);
    vpp_ok = v; send(8'h5A); vpp_ok = 1'b0;
    if (v) begin
      base = int'(alo) & 8'hF8; pg = base / 32;
      if (sm[0][pg]) for (int i = 0; i < 8; i++) mm[base+i] = mm[base+i] & d[8*i +: 8];
      for (int i = 0; i < 8; i++) begin
        recv(r); chk("R8 R10 verify", r, mm[base+i]);
      end
      recv(r); chk("R8 after verify", r, 8'hFF);
    end else begin
      chk("R11 still waiting", {7'd0, rx_ready}, 8'h01);
    end
  endtask

  task automatic t_readf(input int start);
    logic [7:0] r, c;
    busrst(); send(8'hCC); send(8'hF0); send(8'(start)); send(8'h00);
    recv(r); chk("R4 field addr crc", r, crc(crc(crc(8'h00, 8'hF0), 8'(start)), 8'h00));
    chk("R13 ready low in read", {7'd0, rx_ready}, 8'h00);
    c = 8'h00;
    for (int a = start; a < 128; a++) begin
      recv(r); chk("R5 R11 field data", r, mm[a]); c = crc(c, mm[a]);
    end
    recv(r); chk("R5 field crc", r, c);
    recv(r); chk("R5 after crc", r, 8'hFF);
  endtask

  task automatic t_readp(input int start);
    logic [7:0] r, c;
    busrst(); send(8'hCC); send(8'hC3); send(8'(start)); send(8'h00);
    recv(r); chk("R4 page addr crc", r, crc(crc(crc(8'h00, 8'hC3), 8'(start)), 8'h00));
    c = 8'h00;
    for (int a = start; a < 128; a++) begin
      recv(r); chk("R6 page data", r, mm[a]); c = crc(c, mm[a]);
      if (a % 32 == 31) begin
        recv(r); chk("R6 page crc", r, c); c = 8'h00;
      end
    end
    recv(r); chk("R6 after last page", r, 8'hFF);
  endtask

  task automatic t_wstat();
    logic [7:0] r;
    busrst(); send(8'hCC); send(8'h55); send(8'h00); send(8'h00); send(8'hFD);
    recv(r); chk("R9 first crc", r, crc(crc(crc(crc(8'h00, 8'h55), 8'h00), 8'h00), 8'hFD));
    vpp_ok = 1'b1; send(8'h5A); vpp_ok = 1'b0; sm[0] = sm[0] & 8'hFD;
    recv(r); chk("R9 stat verify", r, sm[0]);
    send(8'hFE);
    recv(r); chk("R9 reseeded crc", r, crc(8'h01, 8'hFE));
    vpp_ok = 1'b1; send(8'h5A); vpp_ok = 1'b0; sm[1] = sm[1] & 8'hFE;
    recv(r); chk("R9 stat verify 2", r, sm[1]);
  endtask

  task automatic t_rstat();
    logic [7:0] r, c;
    busrst(); send(8'hCC); send(8'hAA); send(8'h00); send(8'h00);
    recv(r); chk("R4 status addr crc", r, crc(crc(crc(8'h00, 8'hAA), 8'h00), 8'h00));
    c = 8'h00;
    for (int a = 0; a < 8; a++) begin
      recv(r); chk("R7 status data", r, sm[a]); c = crc(c, sm[a]);
    end
    recv(r); chk("R7 status crc", r, c);
    recv(r); chk("R7 after crc", r, 8'hFF);
  endtask

  task automatic t_midrst();
    logic [7:0] r;
    busrst(); send(8'hCC); send(8'hF0); send(8'h00); send(8'h00);
    recv(r); recv(r); recv(r);
    busrst();
    chk("R12 ready after bus reset", {7'd0, rx_ready}, 8'h01);
    send(8'h33);
    recv(r); chk("R12 id after bus reset", r, FAM);
  endtask

  initial begin
    for (int a = 0; a < 128; a++) mm[a] = 8'hFF;
    for (int a = 0; a < 8; a++) sm[a] = (a == 7) ? 8'h00 : 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_nosel();
    t_profile();
    t_wmem(8'h23, 64'h0123_4567_89AB_CDEF, 1'b0);
    t_readf(32'h20);
    t_wmem(8'h23, 64'h0123_4567_89AB_CDEF, 1'b1);
    t_wmem(8'h20, 64'hF0F0_3C3C_AA55_0FF0, 1'b1);
    t_wstat();
    t_rstat();
    t_wmem(8'h20, 64'h0000_0000_0000_0000, 1'b1);
    t_wmem(8'h08, 64'h1122_3344_5566_7788, 1'b1);
    t_readf(32'h1C);
    t_readp(32'h1E);
    t_midrst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R13 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule